// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block derives the SCL clock of an I2C master from a fast reference clock. Standard speed and fast speed each hold their own pair of counts: one for the number of reference cycles SCL stays low and one for the number it stays high. A speed select picks which pair drives the next SCL period. Counts below a fixed floor are raised to that floor: 8 for the low phase and 6 for the high phase. These floors leave room to drive SDA after SCL falls and to sample SDA while SCL is high.

SCL is driven open-drain. An enable output pulls the line low for the whole low phase and lets it go for the high phase. The high phase is only counted once the line reads back high. The block gives one pulse for launching SDA, two cycles after each falling edge, and one pulse for sampling SDA at the middle of the counted high phase. While the master is not enabled, the line is released and the sequencer waits at the start of a low phase.

Top module: `i2c_scl_timegen`

## Requirements
- R1: While enabled, each SCL low phase has `scl_oe` = 1 for exactly the effective low count of reference cycles.
- R2: In the high phase, `scl_oe` = 0. The phase ends after the effective high count of cycles, counted from the first cycle in which `scl_in` reads 1. Cycles before that, while the line is still held low, add to the released time.
- R3: The effective low count is max(programmed low count, 8) and the effective high count is max(programmed high count, 6).
- R4: `fast_sel` = 0 uses `std_hcnt`/`std_lcnt` and `fast_sel` = 1 uses `fast_hcnt`/`fast_lcnt`. The pair that is not selected has no effect on the timing.
- R5: The speed select and the count inputs are captured only when a low phase begins. A change during a period first shows in the next period.
- R6: `launch_stb` pulses exactly once per period, in the third low-phase cycle (index 2, counted from the falling edge as index 0).
- R7: `sample_stb` pulses exactly once per period, at counted high-phase index floor(effective high count / 2), while `scl_in` = 1.
- R8: With `enable` = 0 sampled at a clock edge, the next cycle has `scl_oe` = 0, `phase_o` = 0 and no strobes. After `enable` = 1 is sampled, the next cycle is the first cycle of a full low phase.
- R9: `phase_o` reads 0 when idle, 1 in the low phase and 2 in the high phase.
- R10: While `rst` is high, the block is idle with SCL released and both strobes low, whatever `enable` is.
- R11: With a 10 MHz reference, the counts 46 (high) and 54 (low) give a 100-cycle standard period. The counts 8 (high) and 17 (low) give a 25-cycle fast period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Master mode enable |
| fast_sel | input | 1 | 0 = standard pair, 1 = fast pair |
| std_hcnt | input | CW | Standard-speed high count |
| std_lcnt | input | CW | Standard-speed low count |
| fast_hcnt | input | CW | Fast-speed high count |
| fast_lcnt | input | CW | Fast-speed low count |
| scl_in | input | 1 | SCL level read back from the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| launch_stb | output | 1 | SDA launch pulse in the low phase |
| sample_stb | output | 1 | SDA sample pulse in the high phase |
| phase_o | output | 2 | Current phase: 0 idle, 1 low, 2 high |

## Verification
The checker takes as given that `scl_in` is never high while `scl_oe` pulls the line low. It also takes as given that, once released, the line rises and stays high, with no other master or slave pulling it down in mid-phase. The bench models the line as a pull-up: `scl_in` is the inverse of `scl_oe`, gated by a hold input. The hold is applied only before the high phase begins counting, and it is released on a falling clock edge. Count and mode inputs are changed only on falling clock edges, so every capture edge sees settled values.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int unsigned MIN_LO_CNT = 8;
    localparam int unsigned MIN_HI_CNT = 6;
    localparam int unsigned LAUNCH_OFS = 2;
    localparam int unsigned NUM_SPEEDS = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic launch;
        logic sample;
    } scl_strobe_t;

endpackage

// File: rtl/scl_cnt_latch.sv
module scl_cnt_latch
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          fast_sel,
    input  logic [CW-1:0] std_hcnt,
    input  logic [CW-1:0] std_lcnt,
    input  logic [CW-1:0] fast_hcnt,
    input  logic [CW-1:0] fast_lcnt,
    output logic [CW-1:0] hi_q,
    output logic [CW-1:0] lo_q
);
    localparam logic [CW-1:0] FLOOR_HI = CW'(MIN_HI_CNT);
    localparam logic [CW-1:0] FLOOR_LO = CW'(MIN_LO_CNT);

    logic [CW-1:0] h_raw [NUM_SPEEDS];
    logic [CW-1:0] l_raw [NUM_SPEEDS];
    logic [CW-1:0] h_eff [NUM_SPEEDS];
    logic [CW-1:0] l_eff [NUM_SPEEDS];

    assign h_raw[0] = std_hcnt;
    assign l_raw[0] = std_lcnt;
    assign h_raw[1] = fast_hcnt;
    assign l_raw[1] = fast_lcnt;

    for (genvar m = 0; m < NUM_SPEEDS; m++) begin : g_floor
        assign h_eff[m] = (h_raw[m] < FLOOR_HI) ? FLOOR_HI : h_raw[m];
        assign l_eff[m] = (l_raw[m] < FLOOR_LO) ? FLOOR_LO : l_raw[m];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= FLOOR_HI;
            lo_q <= FLOOR_LO;
        end else if (load) begin
            hi_q <= h_eff[fast_sel];
            lo_q <= l_eff[fast_sel];
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          scl_in,
    input  logic [CW-1:0] hi_q,
    input  logic [CW-1:0] lo_q,
    output scl_phase_e    phase,
    output logic [CW-1:0] cnt,
    output logic          load
);
    logic run_hi;
    logic lo_last;
    logic hi_last;

    assign run_hi  = scl_in || (cnt != '0);
    assign lo_last = (cnt == lo_q - 1'b1);
    assign hi_last = run_hi && (cnt == hi_q - 1'b1);
    assign load    = enable && ((phase == PH_IDLE) || ((phase == PH_HIGH) && hi_last));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (lo_last) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (hi_last) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else if (run_hi) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  scl_phase_e    phase,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] hi_q,
    input  logic          scl_in,
    output scl_strobe_t   stb
);
    localparam logic [CW-1:0] LAUNCH_AT = CW'(LAUNCH_OFS);

    always_comb begin
        stb.launch = (phase == PH_LOW) && (cnt == LAUNCH_AT);
        stb.sample = (phase == PH_HIGH) && scl_in && (cnt == (hi_q >> 1));
    end
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
    import scl_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          fast_sel,
    input  logic [CW-1:0] std_hcnt,
    input  logic [CW-1:0] std_lcnt,
    input  logic [CW-1:0] fast_hcnt,
    input  logic [CW-1:0] fast_lcnt,
    input  logic          scl_in,
    output logic          scl_oe,
    output logic          launch_stb,
    output logic          sample_stb,
    output logic [1:0]    phase_o
);
    scl_phase_e    phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hi_q;
    logic [CW-1:0] lo_q;
    logic          load;
    scl_strobe_t   stb;

    scl_cnt_latch #(.CW(CW)) latch_i (
        .clk(clk), .rst(rst), .load(load), .fast_sel(fast_sel),
        .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
        .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
        .hi_q(hi_q), .lo_q(lo_q)
    );

    scl_phase_fsm #(.CW(CW)) fsm_i (
        .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in),
        .hi_q(hi_q), .lo_q(lo_q), .phase(phase), .cnt(cnt), .load(load)
    );

    scl_strobe_gen #(.CW(CW)) stb_i (
        .phase(phase), .cnt(cnt), .hi_q(hi_q), .scl_in(scl_in), .stb(stb)
    );

    assign scl_oe     = (phase == PH_LOW);
    assign launch_stb = stb.launch;
    assign sample_stb = stb.sample;
    assign phase_o    = phase;
endmodule

// File: rtl/scl_timegen_chk.sv
module scl_timegen_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       scl_in,
    input logic       scl_oe,
    input logic       launch_stb,
    input logic       sample_stb,
    input logic [1:0] phase_o
);
    logic [31:0] lo_run;
    logic [31:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= scl_oe ? lo_run + 1 : 32'd0;
            hi_run <= (phase_o == 2'd2) ? (scl_in ? hi_run + 1 : hi_run) : 32'd0;
        end
    end

    // R3: a low phase that hands over to a high phase lasted at least 8 cycles
    a_r3_low_floor: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && $past(scl_oe) && phase_o == 2'd2) |-> lo_run >= 32'd8);

    // R3: a counted high phase lasted at least 6 cycles
    a_r3_high_floor: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_oe) && $past(phase_o) == 2'd2) |-> hi_run >= 32'd6);

    // R6: launch lands two cycles after the falling edge
    a_r6_launch_pos: assert property (@(posedge clk) disable iff (rst)
        launch_stb |-> (scl_oe && $past(scl_oe) && $past(scl_oe, 2) && !$past(scl_oe, 3)));

    // R7: sampling only while the line is released and reads high
    a_r7_sample_high: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (!scl_oe && scl_in));

    // R8: disable returns to idle on the next cycle
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (phase_o == 2'd0 && !scl_oe));

    // R9: idle means released line and quiet strobes
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd0) |-> (!scl_oe && !launch_stb && !sample_stb));

    // R6, R7: the two strobes never coincide
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({launch_stb, sample_stb}));
endmodule

bind i2c_scl_timegen scl_timegen_chk chk_i (
    .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in), .scl_oe(scl_oe),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .phase_o(phase_o)
);

// File: tb/i2c_scl_timegen_tb_top.sv
module i2c_scl_timegen_tb_top;
    localparam int CW = 16;
    localparam int NV = 6;
    // vector fields: fast select, programmed high, programmed low, expected high, expected low
    localparam int V_FAST [NV] = '{0, 1, 1, 0, 0, 0};
    localparam int V_H    [NV] = '{46, 8, 3, 6, 5, 20};
    localparam int V_L    [NV] = '{54, 17, 2, 8, 7, 9};
    localparam int V_EH   [NV] = '{46, 8, 6, 6, 6, 20};
    localparam int V_EL   [NV] = '{54, 17, 8, 8, 8, 9};

    logic clk = 1'b0;
    logic rst, enable, fast_sel, hold_low, scl_in;
    logic [CW-1:0] std_hcnt, std_lcnt, fast_hcnt, fast_lcnt;
    logic scl_oe, launch_stb, sample_stb;
    logic [1:0] phase_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign scl_in = ~scl_oe & ~hold_low;

    i2c_scl_timegen #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .fast_sel(fast_sel),
        .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
        .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt), .scl_in(scl_in),
        .scl_oe(scl_oe), .launch_stb(launch_stb), .sample_stb(sample_stb),
        .phase_o(phase_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // called at the negedge that shows the first low cycle
    task automatic measure(output int lo, output int hi, output int loff,
                           output int soff, output int nl, output int ns, output int pbad);
        lo = 0; hi = 0; loff = -1; soff = -1; nl = 0; ns = 0; pbad = 0;
        while (scl_oe) begin
            if (launch_stb) begin loff = lo; nl++; end
            if (sample_stb) ns++;
            if (phase_o != 2'd1) pbad++;
            lo++;
            @(negedge clk);
        end
        while (!scl_oe) begin
            if (sample_stb) begin soff = hi; ns++; end
            if (launch_stb) nl++;
            if (phase_o != 2'd2) pbad++;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(input string tag, input int eh, input int el);
        int lo, hi, loff, soff, nl, ns, pbad;
        measure(lo, hi, loff, soff, nl, ns, pbad);
        check({tag, " R1 low length"}, lo, el);
        check({tag, " R2 high length"}, hi, eh);
        check({tag, " R6 launch index"}, loff, 2);
        check({tag, " R6 launch count"}, nl, 1);
        check({tag, " R7 sample index"}, soff, eh / 2);
        check({tag, " R7 sample count"}, ns, 1);
        check({tag, " R9 phase code"}, pbad, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b1; fast_sel = 1'b0; hold_low = 1'b0;
        std_hcnt = 16'd10; std_lcnt = 16'd20; fast_hcnt = 16'd8; fast_lcnt = 16'd17;
        repeat (4) @(negedge clk);
        // R10: reset dominates enable
        check("R10 oe in reset", int'(scl_oe), 0);
        check("R10 phase in reset", int'(phase_o), 0);
        check("R10 strobes in reset", int'(launch_stb | sample_stb), 0);
        enable = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle while disabled", int'(phase_o), 0);

        // vector walk: R1 R2 R3 R4 R6 R7 R9 R11
        for (int i = 0; i < NV; i++) begin
            int lo, hi, loff, soff, nl, ns, pbad;
            enable = 1'b0;
            fast_sel = V_FAST[i][0];
            if (V_FAST[i] != 0) begin
                fast_hcnt = 16'(V_H[i]); fast_lcnt = 16'(V_L[i]);
                std_hcnt = 16'd30; std_lcnt = 16'd40;
            end else begin
                std_hcnt = 16'(V_H[i]); std_lcnt = 16'(V_L[i]);
                fast_hcnt = 16'd31; fast_lcnt = 16'd41;
            end
            repeat (2) @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            check("R8 low starts after enable", int'(scl_oe), 1);
            measure(lo, hi, loff, soff, nl, ns, pbad);
            check("R1 R3 R4 low length", lo, V_EL[i]);
            check("R2 R3 R4 high length", hi, V_EH[i]);
            check("R6 launch index", loff, 2);
            check("R7 sample index", soff, V_EH[i] / 2);
            check("R6 R7 one strobe each", nl * 10 + ns, 11);
            check("R9 phase code", pbad, 0);
            if (i < 2) check("R11 reference period", lo + hi, (i == 0) ? 100 : 25);
            check_period("second period", V_EH[i], V_EL[i]);
        end

        // R5: count change mid-period shows next period
        enable = 1'b0; fast_sel = 1'b0; std_hcnt = 16'd10; std_lcnt = 16'd20;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        std_hcnt = 16'd9; std_lcnt = 16'd12;
        check_period("R5 old counts kept", 10, 20);
        check_period("R5 new counts used", 9, 12);

        // R4 R5: speed switch mid-period
        fast_hcnt = 16'd8; fast_lcnt = 16'd17;
        fast_sel = 1'b1;
        check_period("R4 R5 old speed kept", 9, 12);
        check_period("R4 R5 fast speed used", 8, 17);
        fast_sel = 1'b0; std_hcnt = 16'd10; std_lcnt = 16'd20;
        check_period("R4 back to standard pending", 8, 17);

        // R2: readback held low for the first released cycles
        begin
            int lo, hi, soff;
            lo = 0; hi = 0; soff = -1;
            hold_low = 1'b1;
            while (scl_oe) begin lo++; @(negedge clk); end
            while (!scl_oe) begin
                if (sample_stb) soff = hi;
                hi++;
                if (hi == 4) hold_low = 1'b0;
                @(negedge clk);
            end
            check("R1 low with hold", lo, 20);
            check("R2 released time with hold", hi, 13);
            check("R7 sample after hold", soff, 8);
        end

        // R8: disable mid low phase, then restart
        begin
            int quiet;
            quiet = 0;
            repeat (2) @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            check("R8 oe released on disable", int'(scl_oe), 0);
            check("R8 idle on disable", int'(phase_o), 0);
            for (int k = 0; k < 5; k++) begin
                if (scl_oe || launch_stb || sample_stb || phase_o != 2'd0) quiet++;
                @(negedge clk);
            end
            check("R8 stays quiet", quiet, 0);
            enable = 1'b1;
            @(negedge clk);
            check("R8 restart low", int'(scl_oe), 1);
            check_period("R8 full period after restart", 10, 20);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule